// File: doc/BRIEF.md
# Dual-Channel Storage Controller I/O Window Decoder

This block holds the configuration bytes of a two-channel PCI storage-controller function (ATA/IDE) and derives, for each channel, the I/O window the channel answers to. Each channel has a command block of eight consecutive I/O addresses and a control block of one I/O address. A channel runs either at fixed compatibility addresses or at addresses taken from its own pair of base-address registers (native mode). The mode of each channel is chosen by one bit in the programming-interface byte.

Configuration access is a plain byte port. A write strobe with an address and a data byte updates the register in the same clock edge. The read data is combinational on the address, so it can be taken in the same cycle. No data streams through the block, so there is no valid/ready handshake and no back-pressure: every write strobe is accepted. For an incoming I/O address the block raises a per-channel hit flag, combinationally, when the address falls inside an enabled window. The per-channel window bases and enables are also driven out for the surrounding decode fabric.

Top module: `ide_chan_decode`

## Requirements
- R1: After reset the command byte (address 0x04) reads 0x05, the programming-interface byte (0x09) reads 0x8A, every base-address low byte reads 0x01 and high byte 0x00, and both timing bytes (0x41, 0x43) read 0x00. Both channels are therefore in compatibility mode and not enabled.
- R2: In the programming-interface byte only bit 0 (primary native mode) and bit 2 (secondary native mode) take written values. All other bits keep their reset value.
- R3: A channel in compatibility mode uses command base 0x1F0 with control address 0x3F6 (primary), or 0x170 with 0x376 (secondary). Its base-address registers have no effect.
- R4: A primary channel in native mode takes its command base from the 16-bit value {0x11,0x10} with bits 2:0 cleared. A secondary channel in native mode takes it from {0x19,0x18} in the same way.
- R5: A channel in native mode takes its control address from the control base register with bits 1:0 cleared, plus 2. The control base register is {0x15,0x14} for the primary channel and {0x1D,0x1C} for the secondary channel.
- R6: A write to a base-address low byte (0x10, 0x14, 0x18, 0x1C) stores the byte with bit 0 forced to 1. A write to a high byte (0x11, 0x15, 0x19, 0x1D) stores the byte unchanged.
- R7: A channel is enabled only while command bit 0 is 1 and bit 7 of its timing byte is 1. The primary channel uses the timing byte at 0x41 and the secondary channel uses 0x43.
- R8: A write to a timing byte stores the value ANDed with 0xF3, so bits 3:2 always read 0.
- R9: A channel's hit flag is 1 exactly when the channel is enabled and the I/O address either has the same bits 15:3 as the command base or equals the control address. A disabled channel never hits.
- R10: In the command byte only bits 0 and 2 are writable. All other bits read 0.
- R11: Any configuration address that is not listed above reads 0x00. A write to such an address changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| io_addr | input | 16 | I/O address to be decoded |
| pri_cmd_base | output | 16 | Primary command-block base |
| pri_ctl_addr | output | 16 | Primary control-block address |
| pri_en | output | 1 | Primary window enabled |
| sec_cmd_base | output | 16 | Secondary command-block base |
| sec_ctl_addr | output | 16 | Secondary control-block address |
| sec_en | output | 1 | Secondary window enabled |
| io_hit_pri | output | 1 | io_addr lies in the enabled primary window |
| io_hit_sec | output | 1 | io_addr lies in the enabled secondary window |

## Verification
The hardest case to reach is a native-mode window that does not line up with its raw register value. Here the base-address register holds a value whose low bits are not zero, and the I/O address sits just outside the aligned eight-address block, or one step off the control address computed with the added 2. Random stimulus rarely lands there. So the bench first writes directed unaligned base values and probes the addresses just below, inside and just above each window. It then runs random configuration writes, and after each one it places probe addresses right at the window edges it expects, next to a few uniformly random addresses.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int IO_W = 16;

  localparam logic [7:0] A_CMD = 8'h04;
  localparam logic [7:0] A_PIF = 8'h09;

  localparam logic [7:0] CMD_WMASK = 8'h05;
  localparam logic [7:0] TIM_WMASK = 8'hF3;

  typedef struct packed {
    logic            native;
    logic [IO_W-1:0] cmd_bar;
    logic [IO_W-1:0] ctl_bar;
    logic [7:0]      timing;
  } chan_cfg_t;

  function automatic logic [7:0] cmd_bar_addr(input int ch);
    return 8'(8'h10 + 8 * ch);
  endfunction

  function automatic logic [7:0] ctl_bar_addr(input int ch);
    return 8'(8'h14 + 8 * ch);
  endfunction

  function automatic logic [7:0] timing_addr(input int ch);
    return 8'(8'h41 + 2 * ch);
  endfunction

  function automatic int pif_bit(input int ch);
    return 2 * ch;
  endfunction

endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_dec_pkg::*;
#(
  parameter int         NCH     = 2,
  parameter logic [7:0] CMD_RST = 8'h05,
  parameter logic [7:0] PIF_RST = 8'h8A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic                  io_space_en,
  output chan_cfg_t [NCH-1:0]   chan_o
);

  function automatic logic [7:0] pif_mask();
    logic [7:0] m;
    m = 8'h00;
    for (int c = 0; c < NCH; c++) m[pif_bit(c)] = 1'b1;
    return m;
  endfunction

  localparam logic [7:0] PIF_WMASK = pif_mask();

  logic [7:0] cmd_q;
  logic [7:0] pif_q;
  logic [NCH-1:0][7:0] ch_rd;
  logic [NCH-1:0]      ch_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_RST;
      pif_q <= PIF_RST & ~PIF_WMASK;
    end else if (we) begin
      if (addr == A_CMD) cmd_q <= wdata & CMD_WMASK;
      if (addr == A_PIF) pif_q <= (pif_q & ~PIF_WMASK) | (wdata & PIF_WMASK);
    end
  end

  assign io_space_en = cmd_q[0];

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      localparam logic [7:0] A_CBL = cmd_bar_addr(c);
      localparam logic [7:0] A_CBH = A_CBL + 8'd1;
      localparam logic [7:0] A_KBL = ctl_bar_addr(c);
      localparam logic [7:0] A_KBH = A_KBL + 8'd1;
      localparam logic [7:0] A_TIM = timing_addr(c);

      logic [7:0] cbl_q, cbh_q, kbl_q, kbh_q, tim_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cbl_q <= 8'h01;
          cbh_q <= 8'h00;
          kbl_q <= 8'h01;
          kbh_q <= 8'h00;
          tim_q <= 8'h00;
        end else if (we) begin
          if (addr == A_CBL) cbl_q <= wdata | 8'h01;
          if (addr == A_CBH) cbh_q <= wdata;
          if (addr == A_KBL) kbl_q <= wdata | 8'h01;
          if (addr == A_KBH) kbh_q <= wdata;
          if (addr == A_TIM) tim_q <= wdata & TIM_WMASK;
        end
      end

      assign chan_o[c].native  = pif_q[pif_bit(c)];
      assign chan_o[c].cmd_bar = {cbh_q, cbl_q};
      assign chan_o[c].ctl_bar = {kbh_q, kbl_q};
      assign chan_o[c].timing  = tim_q;

      assign ch_sel[c] = (addr == A_CBL) || (addr == A_CBH) || (addr == A_KBL) ||
                         (addr == A_KBH) || (addr == A_TIM);
      assign ch_rd[c] = (addr == A_CBL) ? cbl_q :
                        (addr == A_CBH) ? cbh_q :
                        (addr == A_KBL) ? kbl_q :
                        (addr == A_KBH) ? kbh_q :
                        (addr == A_TIM) ? tim_q : 8'h00;

      // R8: timing bits 3:2 stay clear after a write
      assert_timing_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_TIM) |=> (tim_q[3:2] == 2'b00));

      // R6: low base byte marked as I/O after a write
      assert_bar_io_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == A_CBL || addr == A_KBL)) |=> (cbl_q[0] && kbl_q[0]));
    end
  endgenerate

  always_comb begin
    rdata = 8'h00;
    if (addr == A_CMD) rdata = cmd_q;
    else if (addr == A_PIF) rdata = pif_q;
    else begin
      for (int k = 0; k < NCH; k++)
        if (ch_sel[k]) rdata = ch_rd[k];
    end
  end

  // R2: read-only programming-interface bits never move
  assert_pif_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pif_q & ~PIF_WMASK) == $past(pif_q & ~PIF_WMASK)));

  // R10: command byte never carries bits outside the writable set
  assert_cmd_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CMD) |=> ((cmd_q & ~CMD_WMASK) == 8'h00));

endmodule

// File: rtl/ide_chan_window.sv
module ide_chan_window #(
  parameter int             AW        = 16,
  parameter int             CMD_ALIGN = 3,
  parameter int             CTL_ALIGN = 2,
  parameter logic [AW-1:0]  CTL_OFS   = 2,
  parameter logic [AW-1:0]  LEG_CMD   = 16'h01F0,
  parameter logic [AW-1:0]  LEG_CTL   = 16'h03F6
) (
  input  logic          native,
  input  logic [AW-1:0] cmd_bar,
  input  logic [AW-1:0] ctl_bar,
  input  logic          io_en,
  input  logic          dec_en,
  output logic [AW-1:0] base,
  output logic [AW-1:0] ctl,
  output logic          en
);

  localparam logic [AW-1:0] CMD_MASK = ~((AW'(1) << CMD_ALIGN) - AW'(1));
  localparam logic [AW-1:0] CTL_MASK = ~((AW'(1) << CTL_ALIGN) - AW'(1));

  logic [AW-1:0] nat_base;
  logic [AW-1:0] nat_ctl;

  assign nat_base = cmd_bar & CMD_MASK;
  assign nat_ctl  = (ctl_bar & CTL_MASK) + CTL_OFS;

  assign base = native ? nat_base : LEG_CMD;
  assign ctl  = native ? nat_ctl  : LEG_CTL;
  assign en   = io_en & dec_en;

endmodule

// File: rtl/ide_io_match.sv
module ide_io_match #(
  parameter int AW        = 16,
  parameter int SPAN_BITS = 3
) (
  input  logic [AW-1:0] io_addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] ctl,
  input  logic          en,
  output logic          hit
);

  logic cmd_hit;
  logic ctl_hit;

  assign cmd_hit = (io_addr[AW-1:SPAN_BITS] == base[AW-1:SPAN_BITS]);
  assign ctl_hit = (io_addr == ctl);
  assign hit     = en && (cmd_hit || ctl_hit);

endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode
  import ide_dec_pkg::*;
#(
  parameter logic [IO_W-1:0] PRI_LEG_CMD = 16'h01F0,
  parameter logic [IO_W-1:0] PRI_LEG_CTL = 16'h03F6,
  parameter logic [IO_W-1:0] SEC_LEG_CMD = 16'h0170,
  parameter logic [IO_W-1:0] SEC_LEG_CTL = 16'h0376,
  parameter int              SPAN_BITS   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic [IO_W-1:0] io_addr,
  output logic [IO_W-1:0] pri_cmd_base,
  output logic [IO_W-1:0] pri_ctl_addr,
  output logic            pri_en,
  output logic [IO_W-1:0] sec_cmd_base,
  output logic [IO_W-1:0] sec_ctl_addr,
  output logic            sec_en,
  output logic            io_hit_pri,
  output logic            io_hit_sec
);

  localparam int NCH = 2;

  chan_cfg_t [NCH-1:0]            ccfg;
  logic                           io_space_en;
  logic [NCH-1:0][IO_W-1:0]       w_base;
  logic [NCH-1:0][IO_W-1:0]       w_ctl;
  logic [NCH-1:0]                 w_en;
  logic [NCH-1:0]                 w_hit;

  ide_cfg_regs #(.NCH(NCH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .rdata       (cfg_rdata),
    .io_space_en (io_space_en),
    .chan_o      (ccfg)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_win
      localparam logic [IO_W-1:0] LCMD = (c == 0) ? PRI_LEG_CMD : SEC_LEG_CMD;
      localparam logic [IO_W-1:0] LCTL = (c == 0) ? PRI_LEG_CTL : SEC_LEG_CTL;

      ide_chan_window #(
        .AW        (IO_W),
        .CMD_ALIGN (SPAN_BITS),
        .LEG_CMD   (LCMD),
        .LEG_CTL   (LCTL)
      ) u_win (
        .native  (ccfg[c].native),
        .cmd_bar (ccfg[c].cmd_bar),
        .ctl_bar (ccfg[c].ctl_bar),
        .io_en   (io_space_en),
        .dec_en  (ccfg[c].timing[7]),
        .base    (w_base[c]),
        .ctl     (w_ctl[c]),
        .en      (w_en[c])
      );

      ide_io_match #(.AW(IO_W), .SPAN_BITS(SPAN_BITS)) u_match (
        .io_addr (io_addr),
        .base    (w_base[c]),
        .ctl     (w_ctl[c]),
        .en      (w_en[c]),
        .hit     (w_hit[c])
      );
    end
  endgenerate

  assign pri_cmd_base = w_base[0];
  assign pri_ctl_addr = w_ctl[0];
  assign pri_en       = w_en[0];
  assign sec_cmd_base = w_base[1];
  assign sec_ctl_addr = w_ctl[1];
  assign sec_en       = w_en[1];
  assign io_hit_pri   = w_hit[0];
  assign io_hit_sec   = w_hit[1];

  // R9: a hit only comes from an enabled window
  assert_hit_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit_pri |-> pri_en) and (io_hit_sec |-> sec_en));

  // R7: clearing the I/O space bit shuts both windows
  assert_io_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_CMD && !cfg_wdata[0]) |=> (!pri_en && !sec_en));

  // R3: compatibility mode selects the fixed primary window
  assert_pri_legacy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_PIF && !cfg_wdata[0])
      |=> (pri_cmd_base == PRI_LEG_CMD && pri_ctl_addr == PRI_LEG_CTL));

endmodule

// File: tb/ide_chan_decode_test.sv
`timescale 1ns/1ps
module ide_chan_decode_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = 16'h0000;
  logic [15:0] pri_cmd_base, pri_ctl_addr, sec_cmd_base, sec_ctl_addr;
  logic        pri_en, sec_en, io_hit_pri, io_hit_sec;

  always #2.5 clk = ~clk;

  ide_chan_decode uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .pri_cmd_base(pri_cmd_base), .pri_ctl_addr(pri_ctl_addr), .pri_en(pri_en),
    .sec_cmd_base(sec_cmd_base), .sec_ctl_addr(sec_ctl_addr), .sec_en(sec_en),
    .io_hit_pri(io_hit_pri), .io_hit_sec(io_hit_sec)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  // shadow of the configuration bytes, kept from the requirements
  logic [7:0] m_cmd, m_pif;
  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];
  logic [7:0] m_tim [2];

  task automatic model_reset();
    m_cmd = 8'h05; m_pif = 8'h8A;
    for (int i = 0; i < 4; i++) begin m_lo[i] = 8'h01; m_hi[i] = 8'h00; end
    m_tim[0] = 8'h00; m_tim[1] = 8'h00;
  endtask

  function automatic int bar_idx(input logic [7:0] a);
    case (a)
      8'h10, 8'h11: return 0;
      8'h14, 8'h15: return 1;
      8'h18, 8'h19: return 2;
      8'h1C, 8'h1D: return 3;
      default:      return -1;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int bi;
    bi = bar_idx(a);
    if (a == 8'h04) m_cmd = d & 8'h05;
    else if (a == 8'h09) m_pif = (m_pif & 8'hFA) | (d & 8'h05);
    else if (a == 8'h41) m_tim[0] = d & 8'hF3;
    else if (a == 8'h43) m_tim[1] = d & 8'hF3;
    else if (bi >= 0) begin
      if (a[0]) m_hi[bi] = d;
      else      m_lo[bi] = d | 8'h01;
    end
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int bi;
    bi = bar_idx(a);
    if (a == 8'h04) return m_cmd;
    if (a == 8'h09) return m_pif;
    if (a == 8'h41) return m_tim[0];
    if (a == 8'h43) return m_tim[1];
    if (bi >= 0) return a[0] ? m_hi[bi] : m_lo[bi];
    return 8'h00;
  endfunction

  function automatic logic [15:0] exp_base(input int ch);
    if (m_pif[2*ch]) return {m_hi[2*ch], m_lo[2*ch]} & 16'hFFF8;
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [15:0] exp_ctl(input int ch);
    if (m_pif[2*ch]) return ({m_hi[2*ch+1], m_lo[2*ch+1]} & 16'hFFFC) + 16'd2;
    return (ch == 0) ? 16'h03F6 : 16'h0376;
  endfunction

  function automatic logic exp_en(input int ch);
    return m_cmd[0] & m_tim[ch][7];
  endfunction

  function automatic logic exp_hit(input int ch, input logic [15:0] a);
    return exp_en(ch) && (((a & 16'hFFF8) == exp_base(ch)) || (a == exp_ctl(ch)));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic read_chk(input logic [7:0] a, input string req);
    cfg_addr = a;
    #1;
    chk(req, {24'h0, cfg_rdata}, {24'h0, model_read(a)});
  endtask

  task automatic outs_chk(input string tag);
    #1;
    chk({tag, " R3/R4 pri base"}, {16'h0, pri_cmd_base}, {16'h0, exp_base(0)});
    chk({tag, " R3/R5 pri ctl"},  {16'h0, pri_ctl_addr}, {16'h0, exp_ctl(0)});
    chk({tag, " R7 pri en"},      {31'h0, pri_en},       {31'h0, exp_en(0)});
    chk({tag, " R3/R4 sec base"}, {16'h0, sec_cmd_base}, {16'h0, exp_base(1)});
    chk({tag, " R3/R5 sec ctl"},  {16'h0, sec_ctl_addr}, {16'h0, exp_ctl(1)});
    chk({tag, " R7 sec en"},      {31'h0, sec_en},       {31'h0, exp_en(1)});
  endtask

  task automatic probe(input logic [15:0] a, input string tag);
    io_addr = a;
    #1;
    chk({tag, " R9 hit pri"}, {31'h0, io_hit_pri}, {31'h0, exp_hit(0, a)});
    chk({tag, " R9 hit sec"}, {31'h0, io_hit_sec}, {31'h0, exp_hit(1, a)});
  endtask

  task automatic edge_probes(input int ch, input string tag);
    logic [15:0] b, k;
    b = exp_base(ch); k = exp_ctl(ch);
    probe(b - 16'd1, tag); probe(b, tag); probe(b + 16'd7, tag);
    probe(b + 16'd8, tag); probe(k - 16'd1, tag); probe(k, tag); probe(k + 16'd1, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  localparam logic [7:0] PICK [13] = '{8'h04, 8'h09, 8'h10, 8'h11, 8'h14, 8'h15,
                                       8'h18, 8'h19, 8'h1C, 8'h1D, 8'h41, 8'h43, 8'h00};

  initial begin
    logic [7:0] a, d;
    void'($urandom(32'd20517));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_chk(8'h04, "R1 cmd reset");
    read_chk(8'h09, "R1 pif reset");
    read_chk(8'h10, "R1 bar lo reset");
    read_chk(8'h1D, "R1 bar hi reset");
    read_chk(8'h41, "R1 timing reset");
    outs_chk("R1");

    // R10 command mask, R2 programming-interface mask, R8 timing mask
    cfg_write(8'h04, 8'hFF); read_chk(8'h04, "R10 cmd mask");
    cfg_write(8'h41, 8'hFF); read_chk(8'h41, "R8 timing mask");
    cfg_write(8'h43, 8'h8C); read_chk(8'h43, "R8 timing mask sec");
    outs_chk("R7 enabled legacy");
    edge_probes(0, "R3 legacy pri");
    edge_probes(1, "R3 legacy sec");

    // R6 and R4/R5 with unaligned bar values, still legacy (R3: bars ignored)
    cfg_write(8'h10, 8'h36); read_chk(8'h10, "R6 bar lo forced");
    cfg_write(8'h11, 8'h12); read_chk(8'h11, "R6 bar hi");
    cfg_write(8'h14, 8'h45);
    cfg_write(8'h15, 8'h20);
    outs_chk("R3 bars ignored");
    cfg_write(8'h09, 8'hFF); read_chk(8'h09, "R2 pif mask");
    outs_chk("R4 native");
    chk("R4 pri base value", {16'h0, pri_cmd_base}, 32'h1230);
    chk("R5 pri ctl value", {16'h0, pri_ctl_addr}, 32'h2046);
    edge_probes(0, "R4 native pri");
    edge_probes(1, "R5 native sec");

    // R11 unmapped address
    cfg_write(8'h3C, 8'hA5); read_chk(8'h3C, "R11 unmapped read");
    outs_chk("R11 unmapped write");

    // R7 I/O enable off
    cfg_write(8'h04, 8'h04);
    outs_chk("R7 io off");
    edge_probes(0, "R7 io off");

    // random phase
    for (int it = 0; it < 400; it++) begin
      a = ($urandom % 5 == 0) ? 8'($urandom) : PICK[$urandom % 13];
      d = 8'($urandom);
      if (a == 8'h04 && ($urandom % 3 != 0)) d[0] = 1'b1;
      if ((a == 8'h41 || a == 8'h43) && ($urandom % 3 != 0)) d[7] = 1'b1;
      cfg_write(a, d);
      read_chk(a, "R2/R6/R8/R10/R11 rand read");
      outs_chk("rand");
      edge_probes(int'($urandom % 2), "rand edge");
      probe(16'($urandom), "rand any");
    end

    summary();
  end

endmodule